// File: doc/BRIEF.md
# Chainable Serial Switch-Enable Register

This block receives an eight-bit word over a three-wire serial link and drives eight independent switch-enable outputs from it. A host pulls the active-low select line down, toggles the serial clock once per bit while presenting data, then releases select. Only at that release do the enable outputs take on the new word. Until then they keep their old values, so a partly shifted word never reaches the switches. Any pattern of the eight enables is legal, from none to all.

The serial output is the last stage of the shift register. It is re-timed to the falling edge of the serial clock. Several units can therefore share clock and select with each output feeding the next unit's data input. A 16-bit stream then loads two units in one select window. The word meant for the far unit goes first.

An asynchronous active-low reset clears the shift register, the serial output and the enable latch. All switches are then off.

Top module: `swctl_chain`

## Requirements
- R1: While `sel_n` is low, `sdi` is sampled into the shift register on each rising edge of `sclk`.
- R2: `sdo` updates only on falling edges of `sclk` while `sel_n` is low. It carries the bit received eight rising edges earlier, so a second unit with its `sdi` tied to `sdo` receives the stream delayed by one word.
- R3: Bits arrive most significant first. The first bit of a word lands in bit 7, and bit n of the loaded word drives `sw_en[n]` (bit 0 is switch 0).
- R4: `sw_en` keeps its previous value during the whole select-low shifting period.
- R5: On the rising edge of `sel_n`, all eight `sw_en` bits are loaded at once from the shift register, whether `sclk` is high or low at that moment.
- R6: While `sel_n` is high, edges on `sclk` and changes on `sdi` have no effect. `sdo` holds the first bit of the last word.
- R7: If a select-low period holds fewer or more than eight clocks, the register keeps the last eight bits received, oldest in bit 7.
- R8: Driving `rst_n` low clears the shift register, `sdo` and `sw_en` to zero at once.
- R9: A 1 in a word bit closes (enables) that switch and a 0 opens it. All ones enables every switch and all zeros disables every switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous clear, active low |
| sel_n | input | 1 | Select, active low; its rising edge loads the enables |
| sclk | input | 1 | Serial clock; data captured on rising edges |
| sdi | input | 1 | Serial data in, most significant bit first |
| sdo | output | 1 | Serial data out, updated on falling edges, for chaining |
| sw_en | output | 8 | Switch enables, 1 = switch closed |

## Verification
The checks assume the host never moves `sel_n` at the same instant as an `sclk` edge, and never changes `sdi` at the instant `sclk` rises. Under that assumption, `sw_en` can only change at a select rise, and `sdo` can only change between select fall and select rise. The bench drives every pin from one tick task. The task changes at most one of `sclk` and `sel_n` per bench clock, and it sets `sdi` a full tick before the rising edge that samples it. Select rises are placed with `sclk` both low and high.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
  localparam int unsigned SWCTL_BITS_DEF = 8;
  typedef logic [SWCTL_BITS_DEF-1:0] swctl_word_t;
endpackage

// File: rtl/swctl_shift.sv
module swctl_shift #(
  parameter int unsigned BITS = 8
) (
  input  logic            rst_n,
  input  logic            sel_n,
  input  logic            sclk,
  input  logic            sdi,
  output logic [BITS-1:0] shift_q
);
  localparam int unsigned TOP = BITS - 1;

  // capture on rising serial clock, newest bit enters at bit 0
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else if (!sel_n) begin
      shift_q <= {shift_q[TOP-1:0], sdi};
    end
  end
endmodule

// File: rtl/swctl_tap.sv
module swctl_tap (
  input  logic rst_n,
  input  logic sel_n,
  input  logic sclk,
  input  logic msb,
  output logic sdo
);
  // falling-edge retime of the last stage so the next unit sees a half period of setup
  always_ff @(negedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      sdo <= 1'b0;
    end else if (!sel_n) begin
      sdo <= msb;
    end
  end
endmodule

// File: rtl/swctl_latch.sv
module swctl_latch #(
  parameter int unsigned BITS = 8
) (
  input  logic            rst_n,
  input  logic            sel_n,
  input  logic [BITS-1:0] shift_q,
  output logic [BITS-1:0] sw_en
);
  // one flop per switch, clocked by the select release
  for (genvar i = 0; i < BITS; i++) begin : g_bit
    always_ff @(posedge sel_n or negedge rst_n) begin
      if (!rst_n) begin
        sw_en[i] <= 1'b0;
      end else begin
        sw_en[i] <= shift_q[i];
      end
    end
  end
endmodule

// File: rtl/swctl_chain.sv
module swctl_chain
  import swctl_pkg::*;
#(
  parameter int unsigned BITS = SWCTL_BITS_DEF
) (
  input  logic            rst_n,
  input  logic            sel_n,
  input  logic            sclk,
  input  logic            sdi,
  output logic            sdo,
  output logic [BITS-1:0] sw_en
);
  localparam int unsigned TOP = BITS - 1;

  logic [BITS-1:0] shift_q;

  swctl_shift #(.BITS(BITS)) u_shift (
    .rst_n   (rst_n),
    .sel_n   (sel_n),
    .sclk    (sclk),
    .sdi     (sdi),
    .shift_q (shift_q)
  );

  swctl_tap u_tap (
    .rst_n (rst_n),
    .sel_n (sel_n),
    .sclk  (sclk),
    .msb   (shift_q[TOP]),
    .sdo   (sdo)
  );

  swctl_latch #(.BITS(BITS)) u_latch (
    .rst_n   (rst_n),
    .sel_n   (sel_n),
    .shift_q (shift_q),
    .sw_en   (sw_en)
  );
endmodule

// File: rtl/swctl_chk.sv
module swctl_chk #(
  parameter int unsigned BITS = 8
) (
  input logic            rst_n,
  input logic            sel_n,
  input logic            sclk,
  input logic            sdo,
  input logic [BITS-1:0] sw_en,
  input logic [BITS-1:0] shift_q
);
  logic [BITS-1:0] en_at_fall;
  logic            sdo_at_rise;

  always_ff @(negedge sel_n or negedge rst_n) begin
    if (!rst_n) en_at_fall <= '0;
    else        en_at_fall <= sw_en;
  end

  always_ff @(posedge sel_n or negedge rst_n) begin
    if (!rst_n) sdo_at_rise <= 1'b0;
    else        sdo_at_rise <= sdo;
  end

  // R4: enables frozen while shifting
  p_en_frozen_r4: assert property (@(posedge sclk) disable iff (!rst_n)
    !sel_n |-> (sw_en == en_at_fall));

  // R6: serial output held while deselected
  p_sdo_hold_r6: assert property (@(negedge sclk) disable iff (!rst_n)
    sel_n |-> (sdo == sdo_at_rise));

  // R5: at the next select fall the enables still equal the loaded register
  always @(negedge sel_n) begin
    if (rst_n) begin
      p_load_match_r5: assert (sw_en == shift_q)
        else $error("R5 enables differ from shift register");
    end
  end

  // R8: cleared while reset is held
  p_reset_clear_r8: assert property (@(posedge sel_n)
    !rst_n |-> (sw_en == '0 && sdo == 1'b0 && shift_q == '0));
endmodule

bind swctl_chain swctl_chk #(.BITS(BITS)) u_chk (
  .rst_n   (rst_n),
  .sel_n   (sel_n),
  .sclk    (sclk),
  .sdo     (sdo),
  .sw_en   (sw_en),
  .shift_q (shift_q)
);

// File: tb/swctl_chain_bench.sv
module swctl_chain_bench;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b1;
  logic       sel_n = 1'b1;
  logic       sclk  = 1'b0;
  logic       din   = 1'b0;
  logic       sdo_a, sdo_b;
  logic [7:0] en_a, en_b;

  swctl_chain u_swctl_chain (
    .rst_n (rst_n), .sel_n (sel_n), .sclk (sclk), .sdi (din),
    .sdo (sdo_a), .sw_en (en_a));

  swctl_chain u_swctl_chain_b (
    .rst_n (rst_n), .sel_n (sel_n), .sclk (sclk), .sdi (sdo_a),
    .sdo (sdo_b), .sw_en (en_b));

  int    vectors = 0;
  int    fails   = 0;
  int    cyc     = 0;
  bit    run     = 1'b0;
  string cur_req = "R8";

  bit         hist_a[$];
  bit         hist_b[$];
  logic       m_sdo_a, m_sdo_b;
  logic [7:0] m_en_a, m_en_b;

  function automatic logic [7:0] pack8(input bit h[$]);
    logic [7:0] w;
    for (int k = 0; k < 8; k++) w[7-k] = h[k];
    return w;
  endfunction

  task automatic model_clear();
    hist_a = {};
    hist_b = {};
    for (int k = 0; k < 8; k++) begin
      hist_a.push_back(1'b0);
      hist_b.push_back(1'b0);
    end
    m_sdo_a = 1'b0; m_sdo_b = 1'b0;
    m_en_a = '0;    m_en_b = '0;
  endtask

  task automatic tick(input logic s, input logic c, input logic d);
    logic old_s, old_c;
    bit   into_b;
    @(negedge clk);
    old_s = sel_n; old_c = sclk;
    sel_n = s; sclk = c; din = d;
    if (rst_n) begin
      if (!old_c && c && !s) begin
        into_b = m_sdo_a;
        hist_a.push_back(d);      void'(hist_a.pop_front());
        hist_b.push_back(into_b); void'(hist_b.pop_front());
      end
      if (old_c && !c && !s) begin
        m_sdo_a = hist_a[0];
        m_sdo_b = hist_b[0];
      end
      if (!old_s && s) begin
        m_en_a = pack8(hist_a);
        m_en_b = pack8(hist_b);
      end
    end
    @(posedge clk);
  endtask

  task automatic send(input logic [31:0] v, input int n, input bit close);
    tick(1'b0, 1'b0, din);
    for (int i = n - 1; i >= 0; i--) begin
      tick(1'b0, 1'b0, v[i]);
      tick(1'b0, 1'b1, v[i]);
    end
    tick(1'b0, 1'b0, din);
    if (close) tick(1'b1, 1'b0, din);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
  endtask

  task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // cycle-by-cycle comparison against the behavioural model
  always @(posedge clk) begin
    if (run) begin
      vectors++;
      if (en_a !== m_en_a || en_b !== m_en_b || sdo_a !== m_sdo_a || sdo_b !== m_sdo_b) begin
        fails++;
        $display("FAIL %s got en_a=%h en_b=%h sdo_a=%b sdo_b=%b expected en_a=%h en_b=%h sdo_a=%b sdo_b=%b",
                 cur_req, en_a, en_b, sdo_a, sdo_b, m_en_a, m_en_b, m_sdo_a, m_sdo_b);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      fails++;
      $display("FAIL watchdog got=%0d cycles expected<=200000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    model_clear();
    do_reset();
    run = 1'b1;
    // R8: reset state
    check(en_a, 8'h00, "R8");
    check(en_b, 8'h00, "R8");
    check({7'd0, sdo_b}, 8'h00, "R8");

    // R1 R2 R3 R9: two-word chain load, far word first
    cur_req = "R2";
    send(32'hA53C, 16, 1'b0);
    check(en_a, 8'h00, "R4");          // R4: not yet loaded
    tick(1'b1, 1'b0, din);
    check(en_b, 8'hA5, "R2");
    check(en_a, 8'h3C, "R3");
    check({7'd0, sdo_b}, 8'h01, "R6");

    // R6: clock and data toggled while deselected
    cur_req = "R6";
    for (int k = 0; k < 10; k++) begin
      tick(1'b1, 1'b0, k[0]);
      tick(1'b1, 1'b1, k[0]);
    end
    tick(1'b1, 1'b0, 1'b0);
    check(en_a, 8'h3C, "R6");
    check(en_b, 8'hA5, "R6");
    check({7'd0, sdo_b}, 8'h01, "R6");

    // R7: short then long frame
    cur_req = "R7";
    send(32'h16, 5, 1'b1);
    check(en_a, 8'h96, "R7");
    check(en_b, 8'hA7, "R7");
    send(32'h75A, 11, 1'b1);
    check(en_a, 8'h5A, "R7");
    check(en_b, 8'hB7, "R7");

    // R9: all on, all off
    cur_req = "R9";
    send(32'hFFFF, 16, 1'b1);
    check(en_a, 8'hFF, "R9");
    check(en_b, 8'hFF, "R9");
    send(32'h0000, 16, 1'b1);
    check(en_a, 8'h00, "R9");
    check(en_b, 8'h00, "R9");

    // R5: select released while the serial clock is high
    cur_req = "R5";
    tick(1'b0, 1'b0, din);
    for (int i = 15; i >= 0; i--) begin
      tick(1'b0, 1'b0, 1'(32'h0F81 >> i));
      tick(1'b0, 1'b1, 1'(32'h0F81 >> i));
    end
    tick(1'b1, 1'b1, din);
    check(en_b, 8'h0F, "R5");
    check(en_a, 8'h81, "R5");
    tick(1'b1, 1'b0, din);
    check(en_a, 8'h81, "R6");

    // R8: reset in the middle of a frame
    cur_req = "R8";
    send(32'hB, 4, 1'b0);
    do_reset();
    check(en_a, 8'h00, "R8");
    check(en_b, 8'h00, "R8");
    check({7'd0, sdo_a}, 8'h00, "R8");
    tick(1'b1, 1'b0, din);
    check(en_a, 8'h00, "R8");
    cur_req = "R1";
    send(32'h1234, 16, 1'b1);
    check(en_b, 8'h12, "R1");
    check(en_a, 8'h34, "R1");

    run = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule